// File: doc/BRIEF.md
# Vector Register Byte-Offset Move Unit

This unit transfers 16-bit quantities between a 64-bit scalar register value and a bank of 128-bit vector registers. It also transfers them between the scalar value and a small bank of 16-bit vector control registers. Each vector register is stored as 16 bytes. A move into or out of a vector register is addressed by a 4-bit byte offset, not by a lane number. To reach 16-bit lane n, the offset is 2*n. An odd offset therefore spans two neighbouring lanes. The top offset, 15, has its own rule in each direction: a write is truncated to a single byte, and a read wraps around to byte 0.

The issuing pipeline provides a move opcode, the instruction word and the scalar source value. The unit decodes the register select and the offset from the instruction word. It writes the enabled bytes on the next rising clock edge when the valid strobe is high. The read result is formed combinationally from the stored state and sign-extended to 64 bits.

Top module: `vmove_unit`

## Requirements
- R1: The register select comes from instruction bits 15..11 and the byte offset comes from bits 10..7. All other instruction bits have no effect.
- R2: The to-vector move with offset o < 15 has two effects. Byte o of the selected register takes scalar bits 15..8, and byte o+1 takes scalar bits 7..0. Every other byte is left unchanged. Scalar bits 63..16 are ignored.
- R3: The to-vector move with offset 15 changes only byte 15, which takes scalar bits 15..8. Byte 0 and byte 14 keep their values.
- R4: The from-vector move returns the 16-bit value {byte o, byte o+1} of the selected register, sign-extended to 64 bits.
- R5: The from-vector move with offset 15 returns {byte 15, byte 0}.
- R6: The to-control move stores scalar bits 15..0 in the control register picked by the select field. The from-control move returns that register sign-extended to 64 bits. The byte offset has no effect on either move.
- R7: Control selects 3 and above read as zero, and writes to them change no control register.
- R8: State changes only at a rising clock edge where mv_valid is high. A write opcode presented with mv_valid low leaves all registers unchanged.
- R9: A synchronous reset (rst_n low at a rising edge) clears every vector register and every control register to zero.
- R10: The mv_op encoding is as follows: 2'b00 is to-vector, 2'b01 is from-vector, 2'b10 is to-control and 2'b11 is from-control. For both write opcodes, gpr_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mv_valid | input | 1 | Commits a write opcode at the next rising edge |
| mv_op | input | 2 | Move opcode (see R10) |
| instr | input | 32 | Instruction word holding the select and offset fields |
| gpr_wdata | input | 64 | Scalar source value |
| gpr_rdata | output | 64 | Sign-extended read result |

## Verification
The bench builds the unit with its default parameters: 32 vector registers of 16 bytes each and 3 control registers. With these values, every one of the sixteen byte offsets can be reached in both directions, including the truncating write and the wrapping read at offset 15. Because the select field is 5 bits wide, control selects 3 through 31 are also reachable, and the bench uses them to test the unimplemented-register behaviour. Overlapping writes at consecutive offsets in one register show that untouched bytes keep their values.

// File: rtl/vmove_pkg.sv
package vmove_pkg;
    typedef enum logic [1:0] {
        OP_TO_VEC   = 2'b00,
        OP_FROM_VEC = 2'b01,
        OP_TO_CTL   = 2'b10,
        OP_FROM_CTL = 2'b11
    } mv_op_e;

    localparam int SEL_LSB = 11;
    localparam int SEL_W   = 5;
    localparam int OFF_LSB = 7;
    localparam int OFF_W   = 4;
    localparam int HALF_W  = 16;
endpackage

// File: rtl/vmove_decode.sv
module vmove_decode
    import vmove_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic               valid,
    input  logic [1:0]         op,
    input  logic [INSTR_W-1:0] instr,
    output logic [SEL_W-1:0]   sel,
    output logic [OFF_W-1:0]   off,
    output logic               vec_we,
    output logic               ctl_we,
    output logic               rd_vec,
    output logic               rd_ctl
);
    mv_op_e op_e;
    logic   unused_bits;

    assign op_e        = mv_op_e'(op);
    assign sel         = instr[SEL_LSB +: SEL_W];
    assign off         = instr[OFF_LSB +: OFF_W];
    assign unused_bits = ^{instr[INSTR_W-1:SEL_LSB+SEL_W], instr[OFF_LSB-1:0]};

    always_comb begin
        vec_we = 1'b0;
        ctl_we = 1'b0;
        rd_vec = 1'b0;
        rd_ctl = 1'b0;
        unique case (op_e)
            OP_TO_VEC:   vec_we = valid;
            OP_FROM_VEC: rd_vec = 1'b1;
            OP_TO_CTL:   ctl_we = valid;
            OP_FROM_CTL: rd_ctl = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank #(
    parameter int NREG   = 32,
    parameter int NBYTES = 16,
    localparam int SW    = $clog2(NREG),
    localparam int OW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [OW-1:0] woff,
    input  logic [15:0]   wdata,
    input  logic [SW-1:0] rsel,
    input  logic [OW-1:0] roff,
    output logic [15:0]   rdata
);
    localparam logic [OW-1:0] LAST = OW'(NBYTES - 1);

    typedef struct packed {
        logic [NREG-1:0][NBYTES-1:0][7:0] mem;
    } bank_t;

    bank_t         state_d, state_q;
    logic [OW-1:0] wnext;
    logic [OW-1:0] rnext;

    assign wnext = woff + 1'b1;
    assign rnext = roff + 1'b1;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.mem[wsel][woff] = wdata[15:8];
            if (woff != LAST) begin
                state_d.mem[wsel][wnext] = wdata[7:0];
            end
        end
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rdata = {state_q.mem[rsel][roff], state_q.mem[rsel][rnext]};

    // R2
    low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && woff != LAST) |=> (state_q.mem[$past(wsel)][$past(wnext)] == $past(wdata[7:0])));

    // R3
    top_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && woff == LAST) |=> (state_q.mem[$past(wsel)][0] == $past(state_q.mem[wsel][0])));
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank #(
    parameter int NCREG = 3,
    parameter int SW    = 5,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [NCREG-1:0][DW-1:0] regs;
    } cbank_t;

    cbank_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NCREG; i++) begin
            if (we && sel == SW'(i)) begin
                state_d.regs[i] = wdata;
            end
        end
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCREG; i++) begin
            if (sel == SW'(i)) begin
                rdata = state_q.regs[i];
            end
        end
    end

    // R7
    no_phantom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel >= SW'(NCREG)) |=> $stable(state_q));

    // R6
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel < SW'(NCREG)) |=> (sel != $past(sel) || rdata == $past(wdata)));
endmodule

// File: rtl/vmove_unit.sv
module vmove_unit
    import vmove_pkg::*;
#(
    parameter int NUM_VREGS  = 32,
    parameter int VREG_BYTES = 16,
    parameter int NUM_CREGS  = 3,
    parameter int GPR_W      = 64,
    parameter int INSTR_W    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mv_valid,
    input  logic [1:0]         mv_op,
    input  logic [INSTR_W-1:0] instr,
    input  logic [GPR_W-1:0]   gpr_wdata,
    output logic [GPR_W-1:0]   gpr_rdata
);
    localparam int EXT_W = GPR_W - HALF_W;

    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;
    logic              vec_we, ctl_we, rd_vec, rd_ctl;
    logic [HALF_W-1:0] vec_rd, ctl_rd;
    logic              unused_hi;

    assign unused_hi = ^gpr_wdata[GPR_W-1:HALF_W];

    vmove_decode #(.INSTR_W(INSTR_W)) u_dec (
        .valid  (mv_valid),
        .op     (mv_op),
        .instr  (instr),
        .sel    (sel),
        .off    (off),
        .vec_we (vec_we),
        .ctl_we (ctl_we),
        .rd_vec (rd_vec),
        .rd_ctl (rd_ctl)
    );

    vreg_bank #(.NREG(NUM_VREGS), .NBYTES(VREG_BYTES)) u_vregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we),
        .wsel  (sel),
        .woff  (off),
        .wdata (gpr_wdata[HALF_W-1:0]),
        .rsel  (sel),
        .roff  (off),
        .rdata (vec_rd)
    );

    ctrl_bank #(.NCREG(NUM_CREGS), .SW(SEL_W), .DW(HALF_W)) u_cregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .sel   (sel),
        .wdata (gpr_wdata[HALF_W-1:0]),
        .rdata (ctl_rd)
    );

    always_comb begin
        gpr_rdata = '0;
        if (rd_vec) begin
            gpr_rdata = {{EXT_W{vec_rd[HALF_W-1]}}, vec_rd};
        end else if (rd_ctl) begin
            gpr_rdata = {{EXT_W{ctl_rd[HALF_W-1]}}, ctl_rd};
        end
    end

    // R10
    write_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_op == OP_TO_VEC || mv_op == OP_TO_CTL) |-> (gpr_rdata == '0));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mv_valid && mv_op == OP_FROM_VEC) |=>
        ((mv_op != OP_FROM_VEC || instr[15:7] != $past(instr[15:7])) || $stable(gpr_rdata)));
endmodule

// File: tb/vmove_unit_bench.sv
module vmove_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mv_valid = 1'b0;
    logic [1:0]  mv_op = 2'b01;
    logic [31:0] instr = '0;
    logic [63:0] gpr_wdata = '0;
    logic [63:0] gpr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  ref_v [32][16];
    logic [15:0] ref_c [3];

    localparam logic [15:0] PAT [16] = '{
        16'h8001, 16'h7F02, 16'h1234, 16'hFEDC, 16'h00FF, 16'hFF00, 16'hA55A, 16'h5AA5,
        16'h0180, 16'h8F0F, 16'h3C3C, 16'hC3C3, 16'h7777, 16'h9999, 16'h0BAD, 16'hE1F0
    };

    always #4 clk = ~clk;

    vmove_unit u_vmove_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .mv_valid  (mv_valid),
        .mv_op     (mv_op),
        .instr     (instr),
        .gpr_wdata (gpr_wdata),
        .gpr_rdata (gpr_rdata)
    );

    task automatic clear_ref();
        for (int s = 0; s < 32; s++)
            for (int b = 0; b < 16; b++) ref_v[s][b] = 8'h00;
        for (int c = 0; c < 3; c++) ref_c[c] = 16'h0000;
    endtask

    function automatic logic [63:0] ref_vec(int s, int o);
        logic [15:0] v;
        v = {ref_v[s][o], ref_v[s][(o + 1) % 16]};
        return {{48{v[15]}}, v};
    endfunction

    function automatic logic [63:0] ref_ctl(int s);
        if (s >= 3) return 64'h0;
        return {{48{ref_c[s][15]}}, ref_c[s]};
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input int s, input int o,
                         input logic [15:0] d, input logic v);
        @(negedge clk);
        mv_op     = op;
        instr     = {16'hA5C3, 5'(s), 4'(o), 7'h2B};
        gpr_wdata = {48'hC0FFEE123456, d};
        mv_valid  = v;
    endtask

    task automatic do_write(input logic [1:0] op, input int s, input int o, input logic [15:0] d);
        drive(op, s, o, d, 1'b1);
        @(posedge clk);
        #1 mv_valid = 1'b0;
        if (op == 2'b00) begin
            ref_v[s][o] = d[15:8];
            if (o != 15) ref_v[s][o + 1] = d[7:0];
        end else if (s < 3) begin
            ref_c[s] = d;
        end
    endtask

    task automatic do_read(input logic [1:0] op, input int s, input int o, input string tag);
        drive(op, s, o, 16'h0000, 1'b0);
        #2;
        if (op == 2'b01) check(gpr_rdata, ref_vec(s, o), tag);
        else             check(gpr_rdata, ref_ctl(s), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R8 actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_ref();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset state
        do_read(2'b01, 0, 0, "R9");
        do_read(2'b01, 31, 15, "R9");
        do_read(2'b11, 2, 0, "R9");

        // R2 / R3: walk every offset in one register with overlapping writes
        for (int k = 0; k < 16; k++) begin
            do_write(2'b00, 9, k, PAT[k]);
            do_read(2'b01, 9, k, (k == 15) ? "R3" : "R2");
        end
        // R4 / R5: read back every offset
        for (int k = 0; k < 16; k++) begin
            do_read(2'b01, 9, k, (k == 15) ? "R5" : "R4");
        end

        // R3: offset 15 write leaves bytes 0 and 14 alone
        for (int k = 0; k < 16; k += 2) do_write(2'b00, 3, k, 16'h1100 + 16'(k * 16'h0101));
        do_write(2'b00, 3, 15, 16'h9A7B);
        do_read(2'b01, 3, 14, "R3");
        do_read(2'b01, 3, 15, "R5");
        do_read(2'b01, 3, 0, "R3");

        // R1: select field isolates registers; other instruction bits ignored
        do_read(2'b01, 4, 6, "R1");
        do_write(2'b00, 31, 0, 16'hFFFE);
        do_read(2'b01, 31, 0, "R1");

        // R10: write opcodes present zero
        drive(2'b00, 9, 2, 16'h0000, 1'b0);
        #2 check(gpr_rdata, 64'h0, "R10");
        drive(2'b10, 1, 0, 16'h0000, 1'b0);
        #2 check(gpr_rdata, 64'h0, "R10");

        // R8: write with valid low is ignored
        drive(2'b00, 9, 4, 16'h0000, 1'b0);
        @(posedge clk);
        do_read(2'b01, 9, 4, "R8");
        drive(2'b10, 0, 0, 16'hFFFF, 1'b0);
        @(posedge clk);
        do_read(2'b11, 0, 0, "R8");

        // R6: control moves, offset ignored
        do_write(2'b10, 0, 5, 16'h8123);
        do_write(2'b10, 1, 15, 16'h7ABC);
        do_write(2'b10, 2, 0, 16'hFFFF);
        do_read(2'b11, 0, 9, "R6");
        do_read(2'b11, 1, 0, "R6");
        do_read(2'b11, 2, 3, "R6");

        // R7: unimplemented control selects
        do_write(2'b10, 3, 0, 16'h5555);
        do_write(2'b10, 31, 0, 16'hAAAA);
        do_read(2'b11, 3, 0, "R7");
        do_read(2'b11, 31, 0, "R7");
        do_read(2'b11, 0, 0, "R7");
        do_read(2'b11, 1, 0, "R7");
        do_read(2'b11, 2, 0, "R7");

        // R9: reset in mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        clear_ref();
        do_read(2'b01, 9, 0, "R9");
        do_read(2'b01, 3, 15, "R9");
        do_read(2'b11, 0, 0, "R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule